// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Arbiter

This block chooses which of seven interrupt sources an 8-bit controller core serves next. The sources, in fixed polling order, are:

- external 0
- timer 0
- external 1
- timer 1
- serial port
- external 2
- external 3

The first five arrive as ready-made request levels from their own blocks. Their enables come from the interrupt-enable value and their priority bits from a priority value. Bit 7 of the enable value is a master switch.

The two extra external sources are handled inside the block. They have a pin each, sampled once per machine cycle. One 8-bit extension register packs, for each of them, the priority bit, the enable bit, the pending flag and the trigger-type bit.

The arbiter raises a request with the selected vector address. When the core acknowledges, the arbiter marks the priority level of that source as in service and reports the serviced source as a one-hot strobe. A return strobe from the core ends service of the level entered most recently. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine.

Top module: `irq_arb7`

## Requirements
- R1: After reset `irq_o` is low, `in_svc_o` is 00, `xcon_o` is 00h, and both pin samples read as high.
- R2: The vector is 03h, 0Bh, 13h, 1Bh, 23h, 33h or 3Bh for source index 0 to 6 respectively (external 0, timer 0, external 1, timer 1, serial, external 2, external 3).
- R3: Among requesting sources of the same level, the one with the lowest index wins.
- R4: A source whose priority bit is 1 is high level and wins over any low-level source. `prio_i[k]` is the priority of source k for k<5; `xcon` bits 3 and 7 are the priorities of sources 5 and 6.
- R5: `ie_i[k]` enables source k for k<5, and `xcon` bits 2 and 6 enable sources 5 and 6. Without `ie_i[7]`, no request is raised.
- R6: A high-level request is raised while only the low level is in service. No request is raised while the high level is in service, or while the low level is in service and only low-level requests exist.
- R7: A `reti_i` pulse clears `in_svc_o[1]` if it is set, and otherwise clears `in_svc_o[0]`.
- R8: With its trigger bit (`xcon` bit 0 for source 5, bit 4 for source 6) at 1, a source's pending flag (bit 1 or bit 5) is set on a `mc_tick_i` cycle whose pin sample is 0 while the previous sample was 1. Pin activity between ticks is ignored. The flag is cleared when that source is acknowledged.
- R9: With the trigger bit at 0, the pending flag takes the inverted pin value on every `mc_tick_i` and is not cleared by an acknowledge.
- R10: Writing `xcon_we_i` loads `xcon_wdata_i` into the extension register, with bit 7 high-priority ext3, bit 6 enable ext3, bit 5 pending ext3, bit 4 trigger ext3, and bits 3..0 the same fields for ext2. `xcon_o` reads it back.
- R11: In a cycle with `irq_o` and `ack_i` both high, `src_ack_o` is one-hot at the selected source index and `in_svc_o` gains that source's level at the next edge. In every other cycle `src_ack_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mc_tick_i | input | 1 | machine-cycle strobe that samples the pins |
| ie_i | input | 8 | bit 7 master enable, bits 4..0 source enables |
| prio_i | input | 5 | priority bits of sources 0..4 |
| src_req_i | input | 5 | request levels of sources 0..4 |
| ext2_n_i | input | 1 | active-low pin of source 5 |
| ext3_n_i | input | 1 | active-low pin of source 6 |
| xcon_we_i | input | 1 | extension register write strobe |
| xcon_wdata_i | input | 8 | extension register write data |
| xcon_o | output | 8 | extension register contents |
| irq_o | output | 1 | request to the core |
| irq_vec_o | output | 8 | vector address of the selected source |
| ack_i | input | 1 | core accepts the request |
| reti_i | input | 1 | core returns from a routine |
| src_ack_o | output | 7 | one-hot serviced source |
| in_svc_o | output | 2 | bit 1 high level in service, bit 0 low level |

## Verification
The hardest state to reach from the ports is a nested service: both levels in service at once, entered in the right order through two acknowledges. The bench gets there by first acknowledging a low-level edge request on external 2. It then produces a falling edge on external 3, set to high priority, and acknowledges that as well. From this state it checks that a further low-level request stays blocked. It then issues two returns and checks that they unwind the levels one at a time. Edge and level triggering are distinguished by moving a pin between ticks and by acknowledging a level-mode source that keeps its pin low.

// File: rtl/irq_arb7.sv
module irq_arb7 #(
  parameter int NSRC = 7,
  parameter int NBASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick_i,
  input  logic [7:0]        ie_i,
  input  logic [NBASE-1:0]  prio_i,
  input  logic [NBASE-1:0]  src_req_i,
  input  logic              ext2_n_i,
  input  logic              ext3_n_i,
  input  logic              xcon_we_i,
  input  logic [7:0]        xcon_wdata_i,
  output logic [7:0]        xcon_o,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic [NSRC-1:0]   src_ack_o,
  output logic [1:0]        in_svc_o
);
  localparam int IW = $clog2(NSRC);

  logic [7:0] xcon_q, xcon_d;
  logic       s2_q, s3_q;
  logic [1:0] svc_q, svc_d;
  logic [NSRC-1:0] req, en, pri, act_hi, act_lo;
  logic hi_any, lo_any, take, sel_hi;
  logic [IW-1:0] sel;

  function automatic logic [IW-1:0] first_set(input logic [NSRC-1:0] v);
    first_set = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  assign req = {xcon_q[5], xcon_q[1], src_req_i};
  assign en  = {xcon_q[6], xcon_q[2], ie_i[NBASE-1:0]} & {NSRC{ie_i[7]}};
  assign pri = {xcon_q[7], xcon_q[3], prio_i};
  assign act_hi = req & en & pri;
  assign act_lo = req & en & ~pri;
  assign hi_any = |act_hi;
  assign lo_any = |act_lo;

  assign irq_o  = (hi_any & ~svc_q[1]) | (~hi_any & lo_any & ~|svc_q);
  assign sel_hi = hi_any;
  assign sel    = hi_any ? first_set(act_hi) : first_set(act_lo);
  assign irq_vec_o = 8'h03 + {(sel < IW'(NBASE)) ? 5'(sel) : 5'(sel) + 5'd1, 3'b000};
  assign take   = irq_o & ack_i;
  assign src_ack_o = take ? (NSRC'(1) << sel) : '0;
  assign xcon_o = xcon_q;
  assign in_svc_o = svc_q;

  always_comb begin
    xcon_d = xcon_q;
    if (xcon_we_i) xcon_d = xcon_wdata_i;
    if (take && sel == IW'(5) && xcon_d[0]) xcon_d[1] = 1'b0;
    if (take && sel == IW'(6) && xcon_d[4]) xcon_d[5] = 1'b0;
    if (mc_tick_i) begin
      if (xcon_d[0]) begin
        if (s2_q && !ext2_n_i) xcon_d[1] = 1'b1;
      end else xcon_d[1] = ~ext2_n_i;
      if (xcon_d[4]) begin
        if (s3_q && !ext3_n_i) xcon_d[5] = 1'b1;
      end else xcon_d[5] = ~ext3_n_i;
    end
  end

  always_comb begin
    svc_d = svc_q;
    if (reti_i) begin
      if (svc_d[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (take) svc_d[sel_hi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcon_q <= '0;
      svc_q  <= '0;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
    end else begin
      xcon_q <= xcon_d;
      svc_q  <= svc_d;
      if (mc_tick_i) begin
        s2_q <= ext2_n_i;
        s3_q <= ext3_n_i;
      end
    end
  end

  p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o[2:0] == 3'b011 && irq_vec_o <= 8'h3B));

  p_master_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i[7] |-> !irq_o);

  p_hi_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_o[1] |-> !irq_o);

  p_reti_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && in_svc_o[1]) |=> (!in_svc_o[1] && in_svc_o[0] == $past(in_svc_o[0])));

  p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack_o[5] && xcon_o[0] && !mc_tick_i && !xcon_we_i) |=> !xcon_o[1]);

  p_level_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick_i && !xcon_we_i && !xcon_o[0]) |=> (xcon_o[1] == !$past(ext2_n_i)));

  p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |-> $onehot(src_ack_o));

  p_ack_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && ack_i) |-> (src_ack_o == '0));
endmodule

// File: tb/irq_arb7_tb.sv
module irq_arb7_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick_i = 1'b0;
  logic [7:0] ie_i = '0;
  logic [4:0] prio_i = '0;
  logic [4:0] src_req_i = '0;
  logic ext2_n_i = 1'b1, ext3_n_i = 1'b1;
  logic xcon_we_i = 1'b0;
  logic [7:0] xcon_wdata_i = '0;
  logic [7:0] xcon_o;
  logic irq_o;
  logic [7:0] irq_vec_o;
  logic ack_i = 1'b0, reti_i = 1'b0;
  logic [6:0] src_ack_o;
  logic [1:0] in_svc_o;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  irq_arb7 dut_i (.clk(clk), .rst_n(rst_n), .mc_tick_i(mc_tick_i), .ie_i(ie_i),
    .prio_i(prio_i), .src_req_i(src_req_i), .ext2_n_i(ext2_n_i), .ext3_n_i(ext3_n_i),
    .xcon_we_i(xcon_we_i), .xcon_wdata_i(xcon_wdata_i), .xcon_o(xcon_o), .irq_o(irq_o),
    .irq_vec_o(irq_vec_o), .ack_i(ack_i), .reti_i(reti_i), .src_ack_o(src_ack_o),
    .in_svc_o(in_svc_o));

  // ie, prio, req, exp irq, exp vec
  localparam logic [26:0] TBL [0:8] = '{
    {8'h00, 5'b00000, 5'b11111, 1'b0, 8'h00},
    {8'h9F, 5'b00000, 5'b11111, 1'b1, 8'h03},
    {8'h9F, 5'b00000, 5'b11110, 1'b1, 8'h0B},
    {8'h9F, 5'b00000, 5'b11000, 1'b1, 8'h1B},
    {8'h9F, 5'b10000, 5'b10001, 1'b1, 8'h23},
    {8'h1F, 5'b00000, 5'b11111, 1'b0, 8'h00},
    {8'h84, 5'b00000, 5'b00011, 1'b0, 8'h00},
    {8'h84, 5'b00000, 5'b00111, 1'b1, 8'h13},
    {8'h9F, 5'b00110, 5'b00111, 1'b1, 8'h0B}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); mc_tick_i = 1'b1;
    @(negedge clk); mc_tick_i = 1'b0; #1;
  endtask

  task automatic pulse_ack(input logic [6:0] exp_ack);
    @(negedge clk); ack_i = 1'b1; #1;
    chk("R11 src_ack", {1'b0, src_ack_o}, {1'b0, exp_ack});
    @(negedge clk); ack_i = 1'b0; #1;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0; #1;
  endtask

  task automatic wr_xcon(input logic [7:0] v);
    @(negedge clk); xcon_we_i = 1'b1; xcon_wdata_i = v;
    @(negedge clk); xcon_we_i = 1'b0; #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 in_svc", {6'd0, in_svc_o}, 8'h00);
    chk("R1 xcon", xcon_o, 8'h00);
    rst_n = 1'b1;

    // table: R2 R3 R4 R5
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {ie_i, prio_i, src_req_i} = TBL[i][26:9];
      #1;
      chk("R5 R4 irq", {7'd0, irq_o}, {7'd0, TBL[i][8]});
      if (TBL[i][8]) chk("R2 R3 vec", irq_vec_o, TBL[i][7:0]);
    end
    @(negedge clk); ie_i = 8'h80; prio_i = '0; src_req_i = '0; #1;

    // R10 layout and readback
    wr_xcon(8'hD5);
    chk("R10 readback", xcon_o, 8'hD5);

    // R8 pulse between ticks is ignored
    @(negedge clk); ext2_n_i = 1'b0;
    @(negedge clk); ext2_n_i = 1'b1;
    tick();
    chk("R8 no edge flag", {7'd0, xcon_o[1]}, 8'h00);
    chk("R8 no irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk); ext2_n_i = 1'b0;
    tick();
    chk("R8 edge flag", {7'd0, xcon_o[1]}, 8'h01);
    chk("R2 vec ext2", irq_vec_o, 8'h33);
    pulse_ack(7'b0100000);
    chk("R8 flag cleared", {7'd0, xcon_o[1]}, 8'h00);
    chk("R11 low in svc", {6'd0, in_svc_o}, 8'h01);

    // R6 preemption by high ext3
    @(negedge clk); ext3_n_i = 1'b0;
    tick();
    chk("R6 preempt irq", {7'd0, irq_o}, 8'h01);
    chk("R2 vec ext3", irq_vec_o, 8'h3B);
    pulse_ack(7'b1000000);
    chk("R6 nested svc", {6'd0, in_svc_o}, 8'h03);
    @(negedge clk); ie_i = 8'h81; src_req_i = 5'b00001; #1;
    chk("R6 blocked", {7'd0, irq_o}, 8'h00);

    // R7 unwinding
    pulse_reti();
    chk("R7 pop high", {6'd0, in_svc_o}, 8'h01);
    chk("R6 low blocked by low", {7'd0, irq_o}, 8'h00);
    pulse_reti();
    chk("R7 pop low", {6'd0, in_svc_o}, 8'h00);
    chk("R7 irq again", {7'd0, irq_o}, 8'h01);
    chk("R2 vec ext0", irq_vec_o, 8'h03);

    // R9 level mode on ext2 (pin still low)
    wr_xcon(8'h04);
    tick();
    chk("R9 level flag", {7'd0, xcon_o[1]}, 8'h01);
    chk("R3 ext0 first", irq_vec_o, 8'h03);
    @(negedge clk); ie_i = 8'h80; src_req_i = '0; #1;
    chk("R9 vec", irq_vec_o, 8'h33);
    pulse_ack(7'b0100000);
    chk("R9 flag kept", {7'd0, xcon_o[1]}, 8'h01);
    pulse_reti();
    // R3 ext2 before ext3 (both level, both low)
    wr_xcon(8'h46);
    tick();
    chk("R3 ext2 over ext3", irq_vec_o, 8'h33);
    @(negedge clk); ext2_n_i = 1'b1; ext3_n_i = 1'b1;
    tick();
    chk("R9 flags follow pin", xcon_o & 8'h22, 8'h00);
    chk("R9 no irq", {7'd0, irq_o}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule